// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address to a page table entry by reading translation tables from memory. A walk starts from a context table: the walker reads the entry chosen by the context number, then, while each fetched entry is a pointer to a further table, indexes the next table with a slice of the virtual address. There are up to three such tables below the context table. Each table read is a single 32-bit word fetched over a valid/ready request channel and a response channel that carries data and an error flag.

A walk ends when a leaf entry is found, and the block then reports that entry and the depth it came from. It also ends when an entry is unusable or a read comes back with an error. In that case the block reports a fault status word that gives the depth and a translation-fault code. The requester starts a walk with a start handshake and waits for a one-cycle completion pulse. Caching of translations, permission checks and updates to entry flag bits belong to other blocks.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to address (ctxBase << 4) + (ctxNum << 2), computed 32 bits wide.
- R2: When the entry at depth d (d = 0, 1, 2) has bits [1:0] = 1 (table pointer), the next read goes to ((entry with bits [1:0] cleared) << 4) plus an index times 4. The index is vaddr[31:24] for depth 1, vaddr[23:18] for depth 2 and vaddr[17:12] for depth 3.
- R3: An entry with bits [1:0] = 2 at any depth ends the walk with done high, fault low, resultPte equal to that entry, resultLevel equal to its depth, and faultStatus zero.
- R4: An entry with type 0 or 3 at any depth, or a table pointer at depth 3, ends the walk with fault high, resultPte zero, resultLevel equal to the depth, and faultStatus = (depth << 8) | 0x10. The value 4 sits in bits [4:2] and every other bit is zero.
- R5: A response with memRspErr high ends the walk with the same fault result as an invalid entry at that depth, and the response data is ignored, even when its type bits read as a pointer or a leaf.
- R6: Only one read is outstanding at a time. memReqValid stays high with a stable address until memReqReady, and no further request is made until the response for it has arrived.
- R7: A walk is accepted only while startReady is high, which is exactly when busy is low. A start presented during a walk is ignored: it changes neither the result nor the reads, and it does not begin a second walk.
- R8: busy rises on the cycle after acceptance and stays high through the done cycle. done is high for exactly one cycle, and the result outputs keep their value after it until the next walk completes.
- R9: Any carry out of bit 31 in address formation is dropped.
- R10: After reset the block is idle: startReady high, busy, done and memReqValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request to begin a walk |
| startReady | output | 1 | Walker can accept a walk |
| vaddr | input | 32 | Virtual address to translate |
| ctxBase | input | 32 | Context table pointer |
| ctxNum | input | CTX_W | Context number |
| memReqValid | output | 1 | Table read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Physical byte address of the read |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read data word |
| memRspErr | input | 1 | Read ended in a bus error |
| busy | output | 1 | Walk in progress or result being presented |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The completed walk faulted |
| resultPte | output | 32 | Leaf entry found (zero on fault) |
| resultLevel | output | 2 | Depth where the walk ended |
| faultStatus | output | 32 | Fault status word (zero on success) |

## Verification
A corrupted state register shows up at the ports by the next read request: its address no longer matches the value the bench derives from the previous entry and the virtual address. It can also show up as a request count that is too high or too low. A wrong pending flag shows within one cycle, as a second request before the response or as a request that never comes. A wrong depth shows at completion as the wrong resultLevel or wrong bits [10:8] of the status word. Every walk is checked address by address and at its done pulse, so an error is caught in the cycle it becomes visible.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEVEL_W   = 2;
  localparam int unsigned TBL_SHIFT = 4;
  localparam int unsigned IDX_SCALE = 2;

  // virtual address slice per table depth (1..3)
  localparam int unsigned L1_HI = 31;
  localparam int unsigned L1_LO = 24;
  localparam int unsigned L2_HI = 23;
  localparam int unsigned L2_LO = 18;
  localparam int unsigned L3_HI = 17;
  localparam int unsigned L3_LO = 12;

  localparam logic [1:0] ENT_PTD = 2'd1;
  localparam logic [1:0] ENT_PTE = 2'd2;
  localparam logic [2:0] FT_TRANSLATION = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTX,
    ST_L1,
    ST_L2,
    ST_L3,
    ST_DONE
  } walkState_t;

  typedef struct packed {
    logic               loadStart;
    logic               advance;
    logic               endPte;
    logic               endFault;
    logic [LEVEL_W-1:0] level;
  } dpCtrl_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  output logic       startReady,
  output logic       memReqValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       memRspErr,
  input  logic [1:0] rspType,
  output logic       busy,
  output logic       done,
  output dpCtrl_t    ctl
);

  walkState_t state, stateNext;
  logic pending;
  logic inWalk;
  logic reqFire;
  logic rspFire;
  logic lastLevel;

  always_comb begin
    inWalk      = (state == ST_CTX) || (state == ST_L1) ||
                  (state == ST_L2)  || (state == ST_L3);
    startReady  = (state == ST_IDLE);
    busy        = !startReady;
    done        = (state == ST_DONE);
    memReqValid = inWalk && !pending;
    reqFire     = memReqValid && memReqReady;
    rspFire     = inWalk && pending && memRspValid;
    lastLevel   = (state == ST_L3);
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_L1:   ctl.level = LEVEL_W'(1);
      ST_L2:   ctl.level = LEVEL_W'(2);
      ST_L3:   ctl.level = LEVEL_W'(3);
      default: ctl.level = '0;
    endcase
    ctl.loadStart = startReady && startValid;
    if (rspFire) begin
      if (memRspErr) begin
        ctl.endFault = 1'b1;
      end else if (rspType == ENT_PTE) begin
        ctl.endPte = 1'b1;
      end else if (rspType == ENT_PTD && !lastLevel) begin
        ctl.advance = 1'b1;
      end else begin
        ctl.endFault = 1'b1;
      end
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctl.loadStart) stateNext = ST_CTX;
      ST_DONE: stateNext = ST_IDLE;
      default: begin
        if (ctl.endPte || ctl.endFault) begin
          stateNext = ST_DONE;
        end else if (ctl.advance) begin
          unique case (state)
            ST_CTX:  stateNext = ST_L1;
            ST_L1:   stateNext = ST_L2;
            default: stateNext = ST_L3;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (reqFire) begin
        pending <= 1'b1;
      end else if (rspFire) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int unsigned CTX_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  input  logic [WORD_W-1:0]   vaddr,
  input  logic [WORD_W-1:0]   ctxBase,
  input  logic [CTX_W-1:0]    ctxNum,
  input  logic [WORD_W-1:0]   rspData,
  output logic [WORD_W-1:0]   reqAddr,
  output logic                fault,
  output logic [WORD_W-1:0]   resultPte,
  output logic [LEVEL_W-1:0]  resultLevel,
  output logic [WORD_W-1:0]   faultStatus
);

  localparam int unsigned NUM_TBL = 3;

  logic [WORD_W-1:0] vaReg;
  logic [WORD_W-1:0] startAddr;
  logic [WORD_W-1:0] nextBase;
  logic [WORD_W-1:0] nextAddr;
  logic [WORD_W-1:0] idxOffset [NUM_TBL];
  logic [WORD_W-1:0] statusWord;

  // byte offset of the entry within each table below the context table
  always_comb begin
    idxOffset[0] = WORD_W'(vaReg[L1_HI:L1_LO]) << IDX_SCALE;
    idxOffset[1] = WORD_W'(vaReg[L2_HI:L2_LO]) << IDX_SCALE;
    idxOffset[2] = WORD_W'(vaReg[L3_HI:L3_LO]) << IDX_SCALE;
  end

  always_comb begin
    startAddr = (ctxBase << TBL_SHIFT) + (WORD_W'(ctxNum) << IDX_SCALE);
    nextBase  = {rspData[WORD_W-1:2], 2'b00} << TBL_SHIFT;
    nextAddr  = nextBase;
    unique case (ctl.level)
      LEVEL_W'(0): nextAddr = nextBase + idxOffset[0];
      LEVEL_W'(1): nextAddr = nextBase + idxOffset[1];
      LEVEL_W'(2): nextAddr = nextBase + idxOffset[2];
      default:     nextAddr = nextBase;
    endcase
    statusWord = (WORD_W'(ctl.level) << 8) | (WORD_W'(FT_TRANSLATION) << 2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg   <= '0;
      reqAddr <= '0;
    end else if (ctl.loadStart) begin
      vaReg   <= vaddr;
      reqAddr <= startAddr;
    end else if (ctl.advance) begin
      reqAddr <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fault       <= 1'b0;
      resultPte   <= '0;
      resultLevel <= '0;
      faultStatus <= '0;
    end else if (ctl.endPte) begin
      fault       <= 1'b0;
      resultPte   <= rspData;
      resultLevel <= ctl.level;
      faultStatus <= '0;
    end else if (ctl.endFault) begin
      fault       <= 1'b1;
      resultPte   <= '0;
      resultLevel <= ctl.level;
      faultStatus <= statusWord;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned CTX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  output logic               startReady,
  input  logic [31:0]        vaddr,
  input  logic [31:0]        ctxBase,
  input  logic [CTX_W-1:0]   ctxNum,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [31:0]        memReqAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  input  logic               memRspErr,
  output logic               busy,
  output logic               done,
  output logic               fault,
  output logic [31:0]        resultPte,
  output logic [1:0]         resultLevel,
  output logic [31:0]        faultStatus
);

  dpCtrl_t ctl;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .startReady  (startReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .rspType     (memRspData[1:0]),
    .busy        (busy),
    .done        (done),
    .ctl         (ctl)
  );

  pt_walker_dp #(.CTX_W(CTX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .vaddr       (vaddr),
    .ctxBase     (ctxBase),
    .ctxNum      (ctxNum),
    .rspData     (memRspData),
    .reqAddr     (memReqAddr),
    .fault       (fault),
    .resultPte   (resultPte),
    .resultLevel (resultLevel),
    .faultStatus (faultStatus)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned CTX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic             startReady,
  input logic [31:0]      ctxBase,
  input logic [CTX_W-1:0] ctxNum,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [31:0]      memReqAddr,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [31:0]      resultPte,
  input logic [1:0]       resultLevel,
  input logic [31:0]      faultStatus
);

  AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startReady) |=> (memReqValid &&
      memReqAddr == (($past(ctxBase) << 4) + (32'($past(ctxNum)) << 2)))); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R6

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid); // R6

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !startReady); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R8

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R8

  AST_FAULT_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (faultStatus[7:0] == 8'h10 && faultStatus[31:11] == '0 &&
      faultStatus[10:8] == {1'b0, resultLevel} && resultPte == '0)); // R4

  AST_LEAF_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (faultStatus == '0 && resultPte[1:0] == 2'd2)); // R3

endmodule

bind pt_walker pt_walker_chk #(.CTX_W(CTX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startValid  (startValid),
  .startReady  (startReady),
  .ctxBase     (ctxBase),
  .ctxNum      (ctxNum),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .resultPte   (resultPte),
  .resultLevel (resultLevel),
  .faultStatus (faultStatus)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  localparam int CTX_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startValid = 1'b0;
  logic             startReady;
  logic [31:0]      vaddr = '0;
  logic [31:0]      ctxBase = '0;
  logic [CTX_W-1:0] ctxNum = '0;
  logic             memReqValid;
  logic             memReqReady = 1'b0;
  logic [31:0]      memReqAddr;
  logic             memRspValid = 1'b0;
  logic [31:0]      memRspData = '0;
  logic             memRspErr = 1'b0;
  logic             busy;
  logic             done;
  logic             fault;
  logic [31:0]      resultPte;
  logic [1:0]       resultLevel;
  logic [31:0]      faultStatus;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pt_walker #(.CTX_W(CTX_W)) u_pt_walker (.*);

  typedef struct packed {
    logic [31:0]       va;
    logic [31:0]       base;
    logic [7:0]        ctx;
    logic [0:3][31:0]  ent;
    logic [0:3]        err;
    logic [2:0]        reads;
    logic              expFault;
    logic [1:0]        expLevel;
    logic [31:0]       expValue;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    // full descent to a depth-3 leaf
    '{32'h1234_5678, 32'h0000_1000, 8'd5,
      {32'h0000_2001, 32'h0000_3001, 32'h0000_4001, 32'hABCD_E0FE}, 4'b0000,
      3'd4, 1'b0, 2'd3, 32'hABCD_E0FE},
    // leaf in the context entry
    '{32'h8000_0000, 32'h0000_0100, 8'd1,
      {32'h00FF_000E, 32'h0, 32'h0, 32'h0}, 4'b0000,
      3'd1, 1'b0, 2'd0, 32'h00FF_000E},
    // invalid entry at depth 1
    '{32'h00C0_0000, 32'h0000_0200, 8'd9,
      {32'h0000_0501, 32'h0000_0000, 32'h0, 32'h0}, 4'b0000,
      3'd2, 1'b1, 2'd1, 32'h0000_0110},
    // bus error at depth 2, data looks like a pointer
    '{32'h4567_8000, 32'h0000_0300, 8'd2,
      {32'h0000_0601, 32'h0000_0701, 32'h0000_5001, 32'h0}, 4'b0010,
      3'd3, 1'b1, 2'd2, 32'h0000_0210},
    // pointer at depth 3
    '{32'hFFFF_F000, 32'h0000_0400, 8'd255,
      {32'h0000_0801, 32'h0000_0901, 32'h0000_0A01, 32'h0000_6001}, 4'b0000,
      3'd4, 1'b1, 2'd3, 32'h0000_0310},
    // reserved type at the context entry
    '{32'h0000_1000, 32'h0000_0500, 8'd0,
      {32'h0000_0003, 32'h0, 32'h0, 32'h0}, 4'b0000,
      3'd1, 1'b1, 2'd0, 32'h0000_0010},
    // bus error at the context entry, data looks like a leaf
    '{32'h0000_2000, 32'h0000_0600, 8'd7,
      {32'h0000_0002, 32'h0, 32'h0, 32'h0}, 4'b1000,
      3'd1, 1'b1, 2'd0, 32'h0000_0010},
    // address wrap in the context and depth-1 reads, leaf at depth 2
    '{32'hFFFC_0000, 32'hF000_0000, 8'd3,
      {32'hF000_0001, 32'h0000_2001, 32'h1234_5676, 32'h0}, 4'b0000,
      3'd3, 1'b0, 2'd2, 32'h1234_5676}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input vec_t v, input int k, input logic [31:0] prev);
    logic [31:0] base;
    logic [31:0] idx;
    if (k == 0) return (v.base << 4) + (32'(v.ctx) << 2);
    base = {prev[31:2], 2'b00} << 4;
    case (k)
      1:       idx = 32'(v.va[31:24]);
      2:       idx = 32'(v.va[23:18]);
      default: idx = 32'(v.va[17:12]);
    endcase
    return base + (idx << 2);
  endfunction

  task automatic runWalk(input vec_t v, input int seed, input bit inject);
    int k = 0;
    int guard = 0;
    logic [31:0] prev = '0;
    chk("R7", 32'(startReady), 32'd1);
    startValid = 1'b1;
    vaddr      = v.va;
    ctxBase    = v.base;
    ctxNum     = v.ctx;
    @(negedge clk);
    startValid = 1'b0;
    chk("R8", 32'(busy), 32'd1);
    if (inject) begin
      startValid = 1'b1;
      vaddr      = 32'h0BAD_0000;
      ctxBase    = 32'h0000_7700;
      ctxNum     = 8'd44;
    end
    while (!done && guard < 400) begin
      guard++;
      if (memReqValid) begin
        if (k > 3) begin
          chk("R6", 32'(k), 32'(v.reads));
          break;
        end
        chk(k == 0 ? "R1" : "R2", memReqAddr, expAddr(v, k, prev));
        if (inject) chk("R7", 32'(startReady), 32'd0);
        repeat ((seed + k) % 3) @(negedge clk);
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        chk("R6", 32'(memReqValid), 32'd0);
        repeat ((seed + k) % 2) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = v.ent[k];
        memRspErr   = v.err[k];
        @(negedge clk);
        memRspValid = 1'b0;
        memRspErr   = 1'b0;
        memRspData  = 32'hDEAD_BEEF;
        prev = v.ent[k];
        k++;
      end else begin
        @(negedge clk);
      end
    end
    startValid = 1'b0;
    chk("R8", 32'(done), 32'd1);
    chk("R6", 32'(k), 32'(v.reads));
    chk(v.expFault ? "R4" : "R3", 32'(fault), 32'(v.expFault));
    chk(v.expFault ? "R4" : "R3", 32'(resultLevel), 32'(v.expLevel));
    if (v.expFault) begin
      chk(v.err != 4'b0 ? "R5" : "R4", faultStatus, v.expValue);
      chk("R4", resultPte, 32'h0);
    end else begin
      chk("R3", resultPte, v.expValue);
      chk("R3", faultStatus, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", 32'(startReady), 32'd1);
    chk("R10", 32'(busy), 32'd0);
    chk("R10", 32'(done), 32'd0);
    chk("R10", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", 32'(startReady), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      runWalk(VECS[i], i, 1'b0);
      @(negedge clk);
      chk("R8", 32'(busy), 32'd0);
    end

    // R9: the wrap vector again, with the wrapped first address checked directly
    chk("R9", expAddr(VECS[7], 0, 32'h0), 32'h0000_000C);

    // R8: results hold after the done pulse
    runWalk(VECS[0], 1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R8", 32'(done), 32'd0);
    chk("R8", resultPte, 32'hABCD_E0FE);
    chk("R8", 32'(resultLevel), 32'd3);

    // R7: a start held high during a walk is ignored
    runWalk(VECS[3], 2, 1'b1);
    @(negedge clk);
    chk("R7", 32'(busy), 32'd0);
    chk("R7", 32'(memReqValid), 32'd0);
    repeat (2) @(negedge clk);
    chk("R7", 32'(memReqValid), 32'd0);
    chk("R7", faultStatus, 32'h0000_0210);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule